// File: doc/BRIEF.md
# DRAM Bank Size Accumulator and Memory Map

The block works out how much system memory is usable from four DRAM banks and turns that figure into memory-map decisions. Two configuration bytes each carry two 3-bit size codes, one per bank. Each code selects a configured bank size from a nonlinear table. The block also receives the installed capacity of every bank in KB. A bank adds to the total only the smaller of its configured size and its installed size.

A start strobe captures the configuration and the installed sizes. The block then adds one bank per clock and publishes the result after the fourth bank. The result has three parts: a conventional-region enable for 0 to 640 KB, an extended-region enable starting at 1 MB, and the extended size in KB. While the sum is being built, the previous map stays on the outputs. A combinational hit output tells whether the access address falls inside any enabled region.

Top module: `dram_size_map`

## Requirements
- R1: Bank 0 takes its code from `cfg_a[2:0]` and bank 1 from `cfg_a[6:4]`. Bank 2 takes its code from `cfg_b[2:0]` and bank 3 from `cfg_b[6:4]`. Bits 3 and 7 of both bytes have no effect.
- R2: A code of 0 or 1 configures 0 KB. A code c from 2 to 7 configures 1024·2^(c−2) KB, giving 1024, 2048, 4096, 8192, 16384 and 32768 KB.
- R3: Bank i contributes min(installed, configured) KB. Its installed size is `bank_kb[16i+15:16i]`. The total is the sum of the four contributions.
- R4: A total above 1024 KB sets `low_en` and `ext_en`, and `ext_kb` is the total minus 1024.
- R5: A total of exactly 1024 KB sets `low_en`, clears `ext_en` and sets `ext_kb` to 0.
- R6: A total below 1024 KB clears both enables and sets `ext_kb` to 0.
- R7: When `start` is seen at a clock edge while idle, `busy` is high for the next four cycles. `done` is then high for exactly one cycle. The new map appears on the same edge that raises `done`.
- R8: `low_en`, `ext_en` and `ext_kb` keep their previous values while `busy` is high.
- R9: `start` has no effect while `busy` is high.
- R10: `addr_hit` is high for every address below 0xA0000 when `low_en` is set.
- R11: When `ext_en` is set, `addr_hit` is high for addresses from 0x100000 up to, but not including, 0x100000 + `ext_kb`·1024.
- R12: The configuration bytes and installed sizes are captured on the edge that accepts `start`. Later changes to them do not affect the run in progress.
- R13: After reset, `busy`, `done`, `low_en`, `ext_en`, `ext_kb` and `addr_hit` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a recalculation |
| cfg_a | input | 8 | Size codes for banks 0 and 1 |
| cfg_b | input | 8 | Size codes for banks 2 and 3 |
| bank_kb | input | 4·KB_W | Installed KB per bank, bank 0 in the low slice |
| addr | input | ADDR_W | Access address to classify |
| busy | output | 1 | Recalculation in progress |
| done | output | 1 | One-cycle pulse when a new map is valid |
| low_en | output | 1 | 0 to 640 KB region enabled |
| ext_en | output | 1 | Region from 1 MB enabled |
| ext_kb | output | KB_W+2 | Extended region size in KB |
| addr_hit | output | 1 | Address lies in an enabled region |

## Verification
The bench walks every code through every bank position. A wrong field slice or a wrong table entry would show up as a wrong total, or as the map landing in the wrong one of the three threshold classes. It uses totals of 1023, 1024 and 1025 KB. A comparison off by one would enable the extended region at exactly 1 MB, or would drop the conventional region. It also runs with installed sizes smaller than the coded ones, where a design that skipped the minimum would report too much memory. Start pulses and input changes arrive during a run; a design that restarted or sampled live inputs would stretch `busy` or report a mixed total. Addresses are probed on both sides of 0xA0000, 0x100000 and the extended end, which catches an inclusive or missing bound.

// File: rtl/dram_size_map.sv
module dram_size_map #(
  parameter int KB_W   = 16,
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [7:0]          cfg_a,
  input  logic [7:0]          cfg_b,
  input  logic [4*KB_W-1:0]   bank_kb,
  input  logic [ADDR_W-1:0]   addr,
  output logic                busy,
  output logic                done,
  output logic                low_en,
  output logic                ext_en,
  output logic [KB_W+1:0]     ext_kb,
  output logic                addr_hit
);

  localparam int NB      = 4;
  localparam int TOT_W   = KB_W + 2;
  localparam int ONE_MB  = 1024;
  localparam int LOW_TOP = 'hA0000;
  localparam int EXT_BOT = 'h100000;

  logic [11:0]         codes_q;
  logic [NB*KB_W-1:0]  kb_q;
  logic [1:0]          idx;
  logic [TOT_W-1:0]    acc;

  logic [2:0]          code;
  logic [TOT_W-1:0]    code_kb;
  logic [TOT_W-1:0]    inst_kb;
  logic [TOT_W-1:0]    part;
  logic [TOT_W-1:0]    sum;

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_a[7], cfg_a[3], cfg_b[7], cfg_b[3]};

  assign code    = codes_q[idx*3 +: 3];
  assign code_kb = (code < 3'd2) ? '0 : (TOT_W'(ONE_MB) << (code - 3'd2));
  assign inst_kb = TOT_W'(kb_q[idx*KB_W +: KB_W]);
  assign part    = (inst_kb < code_kb) ? inst_kb : code_kb;
  assign sum     = acc + part;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      codes_q <= '0;
      kb_q    <= '0;
      idx     <= '0;
      acc     <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      low_en  <= 1'b0;
      ext_en  <= 1'b0;
      ext_kb  <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        acc <= sum;
        idx <= idx + 2'd1;
        if (idx == 2'(NB - 1)) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          low_en <= (sum >= TOT_W'(ONE_MB));
          ext_en <= (sum >  TOT_W'(ONE_MB));
          ext_kb <= (sum >  TOT_W'(ONE_MB)) ? sum - TOT_W'(ONE_MB) : '0;
        end
      end else if (start) begin
        busy    <= 1'b1;
        idx     <= '0;
        acc     <= '0;
        codes_q <= {cfg_b[6:4], cfg_b[2:0], cfg_a[6:4], cfg_a[2:0]};
        kb_q    <= bank_kb;
      end
    end
  end

  logic [ADDR_W:0] ext_end;
  assign ext_end  = (ADDR_W+1)'(EXT_BOT) + ((ADDR_W+1)'(ext_kb) << 10);
  assign addr_hit = (low_en && (addr < ADDR_W'(LOW_TOP))) ||
                    (ext_en && (addr >= ADDR_W'(EXT_BOT)) && ({1'b0, addr} < ext_end));

endmodule

module dram_size_map_chk #(
  parameter int TOT_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             low_en,
  input logic             ext_en,
  input logic [TOT_W-1:0] ext_kb,
  input logic             addr_hit
);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy, 1) && $past(busy, 4) && !$past(busy, 5)));

  // R8
  hold_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($stable(low_en) && $stable(ext_en) && $stable(ext_kb)));

  // R4
  ext_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_en |-> (low_en && ext_kb != '0));

  // R6
  ext_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en |-> (ext_kb == '0));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  // R6
  no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!low_en && !ext_en) |-> !addr_hit);

endmodule

bind dram_size_map dram_size_map_chk #(.TOT_W(KB_W + 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .low_en(low_en), .ext_en(ext_en), .ext_kb(ext_kb), .addr_hit(addr_hit)
);

// File: tb/sim_dram_size_map.sv
module sim_dram_size_map;
  localparam int KB_W = 16;
  localparam int AW   = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [7:0]        cfg_a = '0;
  logic [7:0]        cfg_b = '0;
  logic [4*KB_W-1:0] bank_kb = '0;
  logic [AW-1:0]     addr = '0;
  logic              busy, done, low_en, ext_en, addr_hit;
  logic [KB_W+1:0]   ext_kb;

  always #4 clk = ~clk;

  dram_size_map #(.KB_W(KB_W), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_a(cfg_a), .cfg_b(cfg_b),
    .bank_kb(bank_kb), .addr(addr), .busy(busy), .done(done),
    .low_en(low_en), .ext_en(ext_en), .ext_kb(ext_kb), .addr_hit(addr_hit)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R13";

  int m_busy = 0, m_left = 0, m_done = 0, m_low = 0, m_ext = 0, m_ekb = 0;
  int s_code[4];
  int s_kb[4];

  function automatic int code_size(int c);
    if (c < 2) return 0;
    return 1024 * (1 << (c - 2));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_left = 0; m_done = 0; m_low = 0; m_ext = 0; m_ekb = 0;
    end else begin
      m_done = 0;
      if (m_busy != 0) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          int tot;
          tot = 0;
          for (int i = 0; i < 4; i++) begin
            int c;
            c = code_size(s_code[i]);
            tot += (s_kb[i] < c) ? s_kb[i] : c;
          end
          m_busy = 0;
          m_done = 1;
          m_low  = (tot >= 1024);
          m_ext  = (tot > 1024);
          m_ekb  = (tot > 1024) ? tot - 1024 : 0;
        end
      end else if (start) begin
        s_code[0] = int'(cfg_a[2:0]);
        s_code[1] = int'(cfg_a[6:4]);
        s_code[2] = int'(cfg_b[2:0]);
        s_code[3] = int'(cfg_b[6:4]);
        for (int i = 0; i < 4; i++) s_kb[i] = int'(bank_kb[i*KB_W +: KB_W]);
        m_busy = 1;
        m_left = 4;
      end
    end
  end

  task automatic cmp(string what, longint got, longint exp);
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s got=%0d exp=%0d t=%0t", tag, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    longint a, top;
    int hit;
    a   = longint'(addr);
    top = 64'h100000 + longint'(m_ekb) * 1024;
    hit = ((m_low != 0) && a < 64'hA0000) ||
          ((m_ext != 0) && a >= 64'h100000 && a < top);
    n_cmp++;
    cmp("busy", busy, m_busy);
    cmp("done", done, m_done);
    cmp("low_en", low_en, m_low);
    cmp("ext_en", ext_en, m_ext);
    cmp("ext_kb", ext_kb, m_ekb);
    cmp("addr_hit", addr_hit, hit);
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic set_kb(int k0, int k1, int k2, int k3);
    bank_kb = {16'(k3), 16'(k2), 16'(k1), 16'(k0)};
  endtask

  task automatic run(logic [7:0] a, logic [7:0] b);
    cfg_a = a;
    cfg_b = b;
    start = 1'b1;
    tick(1);
    start = 1'b0;
    tick(6);
  endtask

  task automatic probe_addrs();
    longint e;
    e = 64'h100000 + longint'(ext_kb) * 1024;
    addr = 32'h0;          tick(1);
    addr = 32'h9FFFF;      tick(1);
    addr = 32'hA0000;      tick(1);
    addr = 32'hFFFFF;      tick(1);
    addr = 32'h100000;     tick(1);
    addr = 32'(e - 1);     tick(1);
    addr = 32'(e);         tick(1);
    addr = 32'hFFFFFFFF;   tick(1);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    tag = "R13";
    addr = 32'h1000;
    tick(2);
    rst_n = 1'b1;
    tick(2);

    set_kb(65535, 65535, 65535, 65535);
    for (int b = 0; b < 4; b++) begin
      for (int c = 0; c < 8; c++) begin
        logic [15:0] f;
        tag = (c < 2) ? "R2" : "R1";
        f = '0;
        f[(b / 2) * 8 + (b % 2) * 4 +: 3] = 3'(c);
        f[3] = 1'b1; f[7] = 1'b1; f[11] = 1'b1; f[15] = 1'b1;
        run(f[7:0], f[15:8]);
      end
    end

    tag = "R3";
    set_kb(512, 300, 200, 100);
    run(8'h77, 8'h77);
    tag = "R6";
    set_kb(1023, 0, 0, 0);
    run(8'h07, 8'h00);
    probe_addrs();
    tag = "R5";
    set_kb(1000, 24, 0, 0);
    run(8'h77, 8'h00);
    tag = "R10";
    probe_addrs();
    tag = "R4";
    set_kb(1025, 0, 0, 0);
    run(8'h05, 8'h00);
    tag = "R11";
    probe_addrs();

    tag = "R4";
    set_kb(65535, 65535, 65535, 65535);
    run(8'h77, 8'h77);
    tag = "R11";
    probe_addrs();
    tag = "R3";
    set_kb(3000, 9000, 20000, 40000);
    run(8'h45, 8'h76);
    probe_addrs();

    tag = "R9";
    set_kb(4096, 4096, 0, 0);
    cfg_a = 8'h44; cfg_b = 8'h00;
    start = 1'b1;
    tick(1);
    tag = "R12";
    cfg_a = 8'h22; cfg_b = 8'h77;
    set_kb(1, 1, 1, 1);
    tick(2);
    start = 1'b0;
    tick(6);
    tag = "R8";
    set_kb(2048, 0, 0, 0);
    run(8'h03, 8'h00);
    tag = "R7";
    set_kb(8192, 8192, 8192, 8192);
    cfg_a = 8'h55; cfg_b = 8'h55;
    start = 1'b1;
    tick(12);
    start = 1'b0;
    tick(6);

    tag = "R13";
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule